// File: doc/BRIEF.md
# Radio-Domain PPS Regenerator

This block rebuilds the once-per-second timing pulse inside a radio clock domain whose frequency is an integer multiple of a PLL reference clock. It runs entirely on the radio clock. The incoming pulse-per-second level arrives already synchronous to that clock. A second input carries one single-cycle strobe for each rising edge of the base reference clock.

When the pulse rises, the block counts a programmed number of base-reference edges to reach the point where the base and PLL reference clocks share an edge. From that point it divides the radio clock by the programmed multiplier to recover PLL-reference periods. It counts a programmed number of those periods and then emits a one-cycle pulse. Every cycle of that count begins on a known aligned edge, so the output lands on an edge where all clocks are in phase.

The three programmed fields are written in corrected form. Each one is smaller than the real count by a fixed offset, and the block adds the offset back. A single enable gates the whole function.

Top module: `pps_radio_regen`

## Requirements
- R1: After reset `pps_out` is low and no countdown is active.
- R2: The edge where `pps_in` is first seen high (previous sample low, `enable` high) starts the base phase. The base phase ends on the clock edge that samples the (`base_delay`+1)-th `base_tick` strobe after that start edge.
- R3: The PLL phase follows the base phase. It counts (`pll_delay`+4) PLL-reference periods, each lasting (`mult_sel`+2) radio cycles. If the base phase ends at edge k, `pps_out` is high in the cycle that follows edge k+(`pll_delay`+4)*(`mult_sel`+2).
- R4: `pps_out` is high for exactly one radio cycle per accepted rising edge, and it rises only after a PLL phase.
- R5: A rising edge of `pps_in` that arrives while a countdown is active restarts the countdown from the base phase. The earlier countdown produces no pulse.
- R6: While `enable` is low, both phases are held idle, rising edges are ignored and `pps_out` stays low. Lowering `enable` part way through a countdown discards it, so no pulse follows once `enable` returns high.
- R7: `pps_in` is edge-sensitive. Holding it high for many cycles yields a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Radio clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Enables regeneration; low forces idle |
| pps_in | input | 1 | Pulse-per-second level, synchronous to `clk` |
| base_tick | input | 1 | One-cycle strobe per base-reference rising edge |
| base_delay | input | 8 | Base-reference edges to the aligned edge, minus 1 |
| pll_delay | input | 26 | PLL-reference periods to the output edge, minus 4 |
| mult_sel | input | 2 | Radio/PLL-reference multiplier, minus 2 |
| pps_out | output | 1 | Radio-domain PPS strobe, one cycle |

## Verification
The assertions assume that `mult_sel` does not change during a PLL phase. They also assume that `pps_in` and `base_tick` are already synchronous to the radio clock. The delay fields are taken to be stable for the whole countdown. The stimulus sets all three fields before each run and only changes them while the block is idle. Every input is driven on the falling clock edge. Base-reference strobes come on a fixed grid of 1 to 3 cycles, and they keep arriving through the PLL phase, where the block must ignore them.

// File: rtl/pps_regen_pkg.sv
package pps_regen_pkg;

  // Countdown phase of the regenerator
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BASE = 2'd1,
    PH_PLL  = 2'd2
  } phase_e;

  // Fixed corrections added back to the programmed fields
  localparam int BASE_ADJ = 1;
  localparam int PLL_ADJ  = 4;
  localparam int MULT_ADJ = 2;

endpackage

// File: rtl/pps_rise_detect.sv
module pps_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level_in;
  end

  // The previous sample resets high, so a level that is already high
  // when reset ends is not taken as an edge.
  assign rise_o = level_in & ~level_q;

  // R7
  rise_not_twice_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pps_countdown.sv
module pps_countdown #(
  parameter int W   = 8,
  parameter int ADJ = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         done_o
);

  localparam int CW = $clog2((2 ** W) + ADJ);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(load_val) + CW'(ADJ);
    end else if (step && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign done_o = step && !load && (cnt == CW'(1));

  // R3
  cnt_parked_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));

  // R2
  done_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clear) |=> (cnt == '0));

endmodule

// File: rtl/pps_ref_divider.sv
module pps_ref_divider #(
  parameter int DW  = 2,
  parameter int ADJ = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] sel,
  output logic          wrap_o
);

  localparam int MW = $clog2((2 ** DW) + ADJ);

  logic [MW-1:0] cnt;
  logic [MW-1:0] last;

  assign last   = MW'(sel) + MW'(ADJ) - MW'(1);
  assign wrap_o = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (wrap_o) cnt <= '0;
    else             cnt <= cnt + MW'(1);
  end

  // R3
  div_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= last));

  // R3
  div_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

endmodule

// File: rtl/pps_radio_regen.sv
module pps_radio_regen
  import pps_regen_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int PLL_W  = 26,
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pps_in,
  input  logic              base_tick,
  input  logic [BASE_W-1:0] base_delay,
  input  logic [PLL_W-1:0]  pll_delay,
  input  logic [MULT_W-1:0] mult_sel,
  output logic              pps_out
);

  phase_e phase, phase_nx;
  logic   rise, start;
  logic   base_done, pll_done, ref_wrap;
  logic   fire;

  pps_rise_detect u_rise (
    .clk      (clk),
    .rst      (rst),
    .level_in (pps_in),
    .rise_o   (rise)
  );

  assign start = enable && rise;

  // Base-reference phase: counts base edges to the aligned edge
  pps_countdown #(.W(BASE_W), .ADJ(BASE_ADJ)) u_base_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (!enable || (phase != PH_BASE && !start)),
    .load     (start),
    .load_val (base_delay),
    .step     (base_tick && phase == PH_BASE),
    .done_o   (base_done)
  );

  // Radio-to-PLL-reference divider, aligned at entry of the PLL phase
  pps_ref_divider #(.DW(MULT_W), .ADJ(MULT_ADJ)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (enable && !start && phase == PH_PLL),
    .sel    (mult_sel),
    .wrap_o (ref_wrap)
  );

  // PLL-reference phase: counts PLL periods to the output edge
  pps_countdown #(.W(PLL_W), .ADJ(PLL_ADJ)) u_pll_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (!enable || start),
    .load     (enable && phase == PH_BASE && base_done && !start),
    .load_val (pll_delay),
    .step     (ref_wrap),
    .done_o   (pll_done)
  );

  assign fire = enable && !start && phase == PH_PLL && pll_done;

  always_comb begin
    phase_nx = phase;
    if (!enable) begin
      phase_nx = PH_IDLE;
    end else if (rise) begin
      phase_nx = PH_BASE;
    end else begin
      case (phase)
        PH_BASE: if (base_done) phase_nx = PH_PLL;
        PH_PLL:  if (pll_done)  phase_nx = PH_IDLE;
        default: phase_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      pps_out <= 1'b0;
    end else begin
      phase   <= phase_nx;
      pps_out <= fire;
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pps_out |=> !pps_out);

  // R4
  pulse_after_pll_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pps_out) |-> ($past(phase) == PH_PLL));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pps_out && phase == PH_IDLE));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rise) |=> (phase == PH_BASE && !pps_out));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase == PH_IDLE && !pps_out));

endmodule

// File: tb/pps_radio_regen_tb.sv
`timescale 1ns/1ps
module pps_radio_regen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        pps_in = 1'b0;
  logic        base_tick = 1'b0;
  logic [7:0]  base_delay = '0;
  logic [25:0] pll_delay = '0;
  logic [1:0]  mult_sel = '0;
  logic        pps_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pps_radio_regen u_dut (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .pps_in     (pps_in),
    .base_tick  (base_tick),
    .base_delay (base_delay),
    .pll_delay  (pll_delay),
    .mult_sel   (mult_sel),
    .pps_out    (pps_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One run: rising edge on the edge after the first falling edge (cycle 0).
  // Base strobes arrive on every edge whose cycle index is a multiple of gap.
  task automatic run(input int b, input int p, input int d, input int gap,
                     input int restart_at, input int drop_at, input bit hold,
                     input int span, output int first, output int npulse);
    base_delay = 8'(b);
    pll_delay  = 26'(p);
    mult_sel   = 2'(d);
    @(negedge clk);
    pps_in = 1'b1;
    base_tick = 1'b0;
    first = -1;
    npulse = 0;
    for (int cyc = 1; cyc <= span; cyc++) begin
      @(negedge clk);
      if (pps_out) begin
        npulse++;
        if (first < 0) first = cyc;
      end
      pps_in = hold || (cyc < 3) ||
               (restart_at > 0 && cyc >= restart_at && cyc < restart_at + 2);
      base_tick = (cyc % gap == 0);
      if (drop_at > 0) enable = !(cyc >= drop_at && cyc < drop_at + 2);
    end
    pps_in = 1'b0;
    base_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int first, np, exp, k, gap;
    repeat (3) @(negedge clk);
    check(pps_out == 1'b0, "R1 reset output", pps_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(pps_out == 1'b0, "R1 idle after reset", pps_out, 0);
    enable = 1'b1;

    // Sweep of base delay, PLL delay and multiplier (R2, R3, R4)
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < 4; d++) begin
          gap = 1 + ((b + p + d) % 3);
          exp = gap * (b + 1) + (p + 4) * (d + 2) + 1;
          run(b, p, d, gap, 0, 0, 0, exp + 4, first, np);
          check(first == exp, $sformatf("R2/R3 latency b=%0d p=%0d d=%0d", b, p, d), first, exp);
          check(np == 1, "R4 one pulse per edge", np, 1);
        end

    // Wide field values (R3)
    exp = 1 * (200 + 1) + (1000 + 4) * (3 + 2) + 1;
    run(200, 1000, 3, 1, 0, 0, 0, exp + 4, first, np);
    check(first == exp, "R3 wide fields latency", first, exp);
    check(np == 1, "R4 wide fields single pulse", np, 1);

    // Restart mid-countdown (R5): second edge at cycle 10, gap 2
    k = (10 / 2 + 3 + 1) * 2;
    exp = k + (2 + 4) * (1 + 2) + 1;
    run(3, 2, 1, 2, 10, 0, 0, exp + 6, first, np);
    check(first == exp, "R5 restart latency", first, exp);
    check(np == 1, "R5 earlier countdown dropped", np, 1);

    // Enable dropped in base phase, and in PLL phase (R6)
    run(2, 3, 2, 2, 0, 4, 0, 60, first, np);
    check(np == 0, "R6 drop in base phase", np, 0);
    run(0, 3, 2, 1, 0, 8, 0, 60, first, np);
    check(np == 0, "R6 drop in PLL phase", np, 0);

    // Edge while disabled (R6)
    enable = 1'b0;
    run(0, 0, 0, 1, 0, 0, 0, 30, first, np);
    check(np == 0, "R6 edge ignored while disabled", np, 0);
    enable = 1'b1;
    run(0, 0, 0, 1, 0, 0, 1, 3, first, np);
    pps_in = 1'b1;
    repeat (30) @(negedge clk);
    pps_in = 1'b0;
    enable = 1'b1;

    // Level held high (R7)
    exp = 2 * (1 + 1) + (0 + 4) * (0 + 2) + 1;
    run(1, 0, 0, 2, 0, 0, 1, 80, first, np);
    check(first == exp, "R7 held level latency", first, exp);
    check(np == 1, "R7 held level single pulse", np, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule